// File: doc/BRIEF.md
# Host Cycle Sequencer for a Latched Single-Bit RAM

This block is a clocked master placed between a simple host port and an asynchronous, one-bit-wide static RAM. That RAM captures its address, and in some cycles its write strobe and data, on the falling edge of an active-low enable. The host raises a request with an operation code, a 12-bit address and a write bit. The sequencer then produces the enable, write-enable, address and data waveforms for the chosen cycle shape. When the cycle completes it returns a one-clock completion pulse, which carries the bit that was read.

Four cycle shapes are supported: a plain read, an early write, a late write and a read-modify-write. The early write has the write strobe low before enable falls. In the late write, a write-strobe pulse falls inside the enable-low window. The read-modify-write samples the old bit and then applies a late-write pulse in the same enable-low window. Every minimum interval is a parameter counted in system clocks: address setup, enable-to-data access, write pulse width, data hold after the pulse, and enable-high recovery. Each of these parameters must be at least 1.

Top module: `ramCycleSeq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `ramEnN`=1, `ramWeN`=1, `ready`=1, `done`=0 and `rdData`=0.
- R2: `ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req` and `ready` are both high. A request raised while `ready` is low has no effect on the waveforms, and no cycle is queued for it.
- R3: After a request is taken, `ramAddr` shows the request address with `ramEnN` high for SETUP_CYC clocks before enable falls. `ramAddr` stays unchanged while `ramEnN` is low.
- R4: Every enable-low window lasts at least ACC_CYC clocks.
- R5: Enable stays high for REC_CYC clocks after each window. It does not fall again until at least REC_CYC+SETUP_CYC clocks after it rose.
- R6: For `reqOp`=0 (read), `ramWeN` stays high through the whole cycle. The RAM output is sampled one clock after ACC_CYC enable-low clocks, in an extra enable-low clock.
- R7: For `reqOp`=1 (early write), `ramWeN` goes low together with the address during setup. It stays low until enable rises, with `ramD` holding the write bit.
- R8: For `reqOp`=2 (late write), `ramWeN` is high when enable falls. After ACC_CYC enable-low clocks it is low for WPULSE_CYC clocks, then high for DHOLD_CYC clocks before enable rises. `ramD` is stable throughout.
- R9: For `reqOp`=3 (read-modify-write), the old bit is sampled as in R6. The new bit is then written with the R8 pulse in the same enable-low window. The completion returns the old bit.
- R10: `done` is a one-clock pulse in the first idle cycle after recovery, with `ready` high. `rdData` equals the sampled bit during that pulse for reads and read-modify-writes. It is 0 at all other times and for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| reqOp | input | 2 | Operation: 0 read, 1 early write, 2 late write, 3 read-modify-write |
| reqAddr | input | ADDR_W | Request address |
| reqBit | input | 1 | Bit to write |
| ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-clock completion pulse |
| rdData | output | 1 | Read bit, valid with `done` |
| ramEnN | output | 1 | RAM enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| ramAddr | output | ADDR_W | RAM address |
| ramD | output | 1 | RAM data input |
| ramQ | input | 1 | RAM data output |

## Verification
The assertions check the timing envelope on every cycle:
- the minimum enable-low width and the minimum enable-high recovery, both measured with run counters;
- address stability while enable is low;
- data stability while the write strobe is low;
- the write strobe staying high during reads;
- the single-clock completion pulse.

Only the bench scenarios can show the rest. They confirm that the right shape is produced for each operation code. Against a behavioural RAM that returns corrupt data before the access time has elapsed, they show that read data matches what earlier writes left behind. They also show that read-modify-write returns the old bit, that back-to-back and ignored busy requests behave, and that addresses 0 and 4095 work.

// File: rtl/ramSeqPkg.sv
package ramSeqPkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_EARLY = 2'd1,
    OP_LATE  = 2'd2,
    OP_RMW   = 2'd3
  } seqOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ENLOW,
    ST_SAMPLE,
    ST_WPULSE,
    ST_DHOLD,
    ST_RECOVER
  } seqState_e;

  typedef struct packed {
    logic capture;
    logic sample;
    logic finish;
  } pathStrobe_t;
endpackage

// File: rtl/ramSeqCtrl.sv
module ramSeqCtrl
  import ramSeqPkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int ACC_CYC    = 12,
  parameter int WPULSE_CYC = 4,
  parameter int DHOLD_CYC  = 3,
  parameter int REC_CYC    = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        req,
  input  seqOp_e      op,
  output logic        ready,
  output logic        ramEnN,
  output logic        ramWeN,
  output pathStrobe_t strobe
);
  localparam int M1 = (SETUP_CYC > ACC_CYC) ? SETUP_CYC : ACC_CYC;
  localparam int M2 = (WPULSE_CYC > DHOLD_CYC) ? WPULSE_CYC : DHOLD_CYC;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > REC_CYC) ? M3 : REC_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int HIGH_MIN = REC_CYC + SETUP_CYC;
  localparam int RUN_W = $clog2(ACC_CYC + HIGH_MIN + 2);

  seqState_e state, nxt;
  seqOp_e opR;
  logic [CNT_W-1:0] cnt;
  logic cntZero;

  assign cntZero = (cnt == '0);

  function automatic logic [CNT_W-1:0] loadOf(seqState_e s);
    case (s)
      ST_SETUP:   return CNT_W'(SETUP_CYC - 1);
      ST_ENLOW:   return CNT_W'(ACC_CYC - 1);
      ST_WPULSE:  return CNT_W'(WPULSE_CYC - 1);
      ST_DHOLD:   return CNT_W'(DHOLD_CYC - 1);
      ST_RECOVER: return CNT_W'(REC_CYC - 1);
      default:    return '0;
    endcase
  endfunction

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (req) nxt = ST_SETUP;
      ST_SETUP:   if (cntZero) nxt = ST_ENLOW;
      ST_ENLOW:
        if (cntZero) begin
          if (opR == OP_READ || opR == OP_RMW) nxt = ST_SAMPLE;
          else if (opR == OP_LATE)             nxt = ST_WPULSE;
          else                                 nxt = ST_RECOVER;
        end
      ST_SAMPLE:  nxt = (opR == OP_RMW) ? ST_WPULSE : ST_RECOVER;
      ST_WPULSE:  if (cntZero) nxt = ST_DHOLD;
      ST_DHOLD:   if (cntZero) nxt = ST_RECOVER;
      ST_RECOVER: if (cntZero) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      opR   <= OP_READ;
    end else begin
      state <= nxt;
      if (nxt != state)  cnt <= loadOf(nxt);
      else if (!cntZero) cnt <= cnt - 1'b1;
      if (state == ST_IDLE && req) opR <= op;
    end
  end

  assign ready  = (state == ST_IDLE);
  assign ramEnN = !(state inside {ST_ENLOW, ST_SAMPLE, ST_WPULSE, ST_DHOLD});
  assign ramWeN = !((opR == OP_EARLY && state inside {ST_SETUP, ST_ENLOW})
                    || state == ST_WPULSE);

  assign strobe.capture = (state == ST_IDLE) && req;
  assign strobe.sample  = (state == ST_SAMPLE);
  assign strobe.finish  = (state == ST_RECOVER) && cntZero;

  // Run-length counters used only by the timing checks below
  logic [RUN_W-1:0] lowRun, highRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= RUN_W'(HIGH_MIN);
    end else begin
      if (ramEnN) lowRun <= '0;
      else if (lowRun < RUN_W'(ACC_CYC)) lowRun <= lowRun + 1'b1;
      if (!ramEnN) highRun <= '0;
      else if (highRun < RUN_W'(HIGH_MIN)) highRun <= highRun + 1'b1;
    end
  end

  // R4
  enable_low_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramEnN) |-> lowRun >= RUN_W'(ACC_CYC));

  // R5
  enable_recovery_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramEnN) |-> highRun >= RUN_W'(HIGH_MIN));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(req));

  // R6
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && opR == OP_READ) |-> ramWeN);
endmodule

// File: rtl/ramSeqPath.sv
module ramSeqPath
  import ramSeqPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqBit,
  input  logic              ramQ,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramD,
  output logic              rdData,
  output logic              done
);
  logic [ADDR_W-1:0] addrR;
  logic bitR, rdBitR, doneR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR  <= '0;
      bitR   <= 1'b0;
      rdBitR <= 1'b0;
      doneR  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        addrR  <= reqAddr;
        bitR   <= reqBit;
        rdBitR <= 1'b0;
      end else if (strobe.sample) begin
        rdBitR <= ramQ;
      end
      doneR <= strobe.finish;
    end
  end

  assign ramAddr = addrR;
  assign ramD    = bitR;
  assign done    = doneR;
  assign rdData  = doneR & rdBitR;

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);
endmodule

// File: rtl/ramCycleSeq.sv
module ramCycleSeq
  import ramSeqPkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SETUP_CYC  = 1,
  parameter int ACC_CYC    = 12,
  parameter int WPULSE_CYC = 4,
  parameter int DHOLD_CYC  = 3,
  parameter int REC_CYC    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqBit,
  output logic              ready,
  output logic              done,
  output logic              rdData,
  output logic              ramEnN,
  output logic              ramWeN,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramD,
  input  logic              ramQ
);
  pathStrobe_t strobe;

  ramSeqCtrl #(
    .SETUP_CYC(SETUP_CYC), .ACC_CYC(ACC_CYC), .WPULSE_CYC(WPULSE_CYC),
    .DHOLD_CYC(DHOLD_CYC), .REC_CYC(REC_CYC)
  ) ctrl (
    .clk(clk), .rstN(rstN), .req(req), .op(seqOp_e'(reqOp)),
    .ready(ready), .ramEnN(ramEnN), .ramWeN(ramWeN), .strobe(strobe)
  );

  ramSeqPath #(.ADDR_W(ADDR_W)) path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqBit(reqBit), .ramQ(ramQ), .ramAddr(ramAddr), .ramD(ramD),
    .rdData(rdData), .done(done)
  );

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ramEnN |-> $stable(ramAddr));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ramWeN && $past(!ramWeN)) |-> $stable(ramD));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ready);
endmodule

// File: tb/ramCycleSeq_test.sv
module ramCycleSeq_test;
  localparam int AW = 12, SC = 1, AC = 12, WP = 4, DH = 3, RC = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0, req = 1'b0, reqBit = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic ready, done, rdData, ramEnN, ramWeN, ramD, ramQ;
  logic [AW-1:0] ramAddr;

  always #5 clk = ~clk;

  ramCycleSeq #(.ADDR_W(AW), .SETUP_CYC(SC), .ACC_CYC(AC), .WPULSE_CYC(WP),
                .DHOLD_CYC(DH), .REC_CYC(RC)) uut (
    .clk(clk), .rstN(rstN), .req(req), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqBit(reqBit), .ready(ready), .done(done), .rdData(rdData),
    .ramEnN(ramEnN), .ramWeN(ramWeN), .ramAddr(ramAddr), .ramD(ramD), .ramQ(ramQ));

  // Behavioural latched RAM: latches on enable fall, corrupt data before access time
  bit memArr [DEPTH];
  bit sb [DEPTH];
  logic [AW-1:0] latA = '0;
  int lowCnt = 0;
  logic prevEn = 1'b1, prevWe = 1'b1;

  always @(posedge clk) begin
    prevEn <= ramEnN;
    prevWe <= ramWeN;
    lowCnt <= ramEnN ? 0 : lowCnt + 1;
    if (prevEn && !ramEnN) begin
      latA <= ramAddr;
      if (!ramWeN) memArr[ramAddr] <= ramD;
    end else if (!ramEnN && !prevEn && prevWe && !ramWeN) begin
      memArr[latA] <= ramD;
    end
  end

  assign ramQ = (lowCnt >= AC) ? memArr[latA] : ~memArr[latA];

  // Cycle-by-cycle reference: queue of expected {enN, weN, ready, done, rdData}
  logic [4:0] expQ[$];
  string tagQ[$];
  int checks = 0, fails = 0;

  task automatic cyc();
    logic [4:0] e;
    logic [4:0] act;
    string t;
    @(negedge clk);
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
    end else begin
      e = 5'b11100;
      t = rstN ? "R2" : "R1";
    end
    act = {ramEnN, ramWeN, ready, done, rdData};
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: {enN,weN,ready,done,rd} actual %b expected %b at %0t", t, act, e, $time);
    end
  endtask

  task automatic push(logic [4:0] v, string t, int n);
    repeat (n) begin
      expQ.push_back(v);
      tagQ.push_back(t);
    end
  endtask

  task automatic planOp(logic [1:0] op, logic [AW-1:0] a, logic b);
    logic early, rd;
    early = (op == 2'd1);
    rd = (op == 2'd0) || (op == 2'd3);
    push({1'b1, !early, 3'b000}, "R3", SC);
    push({1'b0, !early, 3'b000}, early ? "R7" : "R4", AC);
    if (rd) push(5'b01000, "R6", 1);
    if (op >= 2'd2) begin
      push(5'b00000, "R8", WP);
      push(5'b01000, "R8", DH);
    end
    push(5'b11000, "R5", RC);
    push({4'b1111, rd ? sb[a] : 1'b0}, (op == 2'd3) ? "R9" : (rd ? "R6" : "R10"), 1);
    if (op != 2'd0) sb[a] = b;
  endtask

  task automatic issue(logic [1:0] op, logic [AW-1:0] a, logic b);
    reqOp = op; reqAddr = a; reqBit = b; req = 1'b1;
    planOp(op, a, b);
    cyc();
    req = 1'b0;
    while (expQ.size() > 0) cyc();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual run still busy, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state, and first cycle after release
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    cyc();
    // R7 then R6 on address 0
    issue(2'd1, 12'd0, 1'b1);
    issue(2'd0, 12'd0, 1'b0);
    // R8 then R6 on the top address
    issue(2'd2, 12'd4095, 1'b1);
    issue(2'd0, 12'd4095, 1'b0);
    // R9: returns old 1, writes 0
    issue(2'd3, 12'd0, 1'b0);
    issue(2'd0, 12'd0, 1'b0);
    issue(2'd3, 12'd4095, 1'b0);
    issue(2'd0, 12'd4095, 1'b0);
    // R2: request held high during a busy cycle with other fields is ignored
    reqOp = 2'd1; reqAddr = 12'd5; reqBit = 1'b1; req = 1'b1;
    planOp(2'd1, 12'd5, 1'b1);
    cyc();
    reqOp = 2'd2; reqAddr = 12'd7; reqBit = 1'b1;
    repeat (3) cyc();
    req = 1'b0;
    while (expQ.size() > 0) cyc();
    issue(2'd0, 12'd5, 1'b0);
    issue(2'd0, 12'd7, 1'b0);
    // Mixed traffic, back-to-back and with idle gaps
    for (int i = 0; i < 80; i++) begin
      logic [AW-1:0] a;
      a = (i % 9 == 0) ? 12'd4095 : AW'($urandom % 8);
      issue(2'($urandom % 4), a, 1'($urandom));
      repeat ($urandom % 3) cyc();
    end
    summary();
    $finish;
  end
endmodule